// File: doc/BRIEF.md
# Message Interrupt Status Bank

This block collects message-signalled interrupts. A requester raises an interrupt by writing one 32-bit word to a single index register. Two fields in that word pick one of eight 32-bit status registers and one bit inside it. The block sets that bit and keeps it set until software reads the register. The block holds one shared interrupt request high while any status bit anywhere is set.

Software services the request in two steps. First it reads a summary register, which has one bit per status register that currently holds anything. Then it reads each flagged status register. Each of those reads returns the register's contents and empties it in the same access. Once every status register is empty, the shared request falls. Routing that request to a processor is the job of a neighbouring block.

The register bus is minimal: a write strobe with its own address and data, a read strobe with its own address, and registered read data. A write and a read may therefore occur in the same cycle.

Top module: `msg_irq_bank`

## Requirements
- R1: After a synchronous active-low reset, every status register is zero, the summary register reads zero and `irq` is low.
- R2: A write to offset 0x140 sets one status bit. Bits 31:29 of the written word give the status register number and bits 28:24 give the bit number. Bits 23:0 are don't-care.
- R3: A read of offset 0x10*k (k = 0..7) returns status register k on `rd_data` in the cycle after `rd_en`. The same edge clears that register, so an immediate second read returns zero.
- R4: A read of offset 0x120 returns a word whose bit k is 1 exactly when status register k is non-zero. All other bits of that word are zero. This read clears nothing.
- R5: A write to any offset other than 0x140 changes no status register and does not affect `irq`.
- R6: `irq` is the OR of all status bits. It rises the cycle after the first index write and falls the cycle after the read that empties the last non-zero status register.
- R7: When an index write and a clearing read target the same status register in the same cycle, the read returns the old contents (without the new bit) and the register is left holding only the new bit.
- R8: A read of any offset that is neither a status register nor the summary register returns zero and changes no state.
- R9: Index writes accumulate. A bit already set stays set, and several writes to one register produce the OR of their bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte offset |
| rd_data | output | 32 | Registered read data, valid the cycle after `rd_en` |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench targets four corner cases:
- The same-cycle write and clearing read of one register. A design that cleared after merging would lose the new bit, and `irq` would stay low with a message pending.
- The extreme bit and register numbers, bit 0 and bit 31 of registers 0 and 7. A mis-sliced select field would set a bit in the wrong place.
- Writes of all-ones to status, summary and unmapped offsets. A careless write decode would set bits there.
- Repeated reads and summary reads. These expose a register that fails to clear, or a summary read that clears state by mistake.

Throughout the random phase, `irq` is compared against the bench model every cycle.

// File: rtl/msg_irq_pkg.sv
// Package: shared offsets and field geometry for the message interrupt bank.
// Assumes byte offsets fit in the address width chosen by the top module.
package msg_irq_pkg;
    localparam int OFF_INDEX    = 'h140;  // index (set) register
    localparam int OFF_SUMMARY  = 'h120;  // non-zero summary register
    localparam int STRIDE_SHIFT = 4;      // status registers every 0x10 bytes
endpackage

// File: rtl/msg_index_decode.sv
// Module: msg_index_decode
// Turns an index-register write into a one-hot set mask across all status
// registers. The register number sits in the top bits of the write word and
// the bit number directly below it. Assumes NUM_BANKS and DATA_W are powers of two.
module msg_index_decode #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                                 wr_en,
    input  logic [ADDR_W-1:0]                    wr_addr,
    input  logic [DATA_W-1:0]                    wr_data,
    output logic [NUM_BANKS-1:0][DATA_W-1:0]     set_mask
);
    import msg_irq_pkg::*;

    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam int BIT_SEL_W  = $clog2(DATA_W);
    localparam int BANK_LSB   = DATA_W - BANK_SEL_W;
    localparam int BIT_LSB    = BANK_LSB - BIT_SEL_W;

    logic                  hit;
    logic [BANK_SEL_W-1:0] bank_sel;
    logic [BIT_SEL_W-1:0]  bit_sel;
    logic                  unused_low;

    assign hit        = wr_en && (wr_addr == ADDR_W'(OFF_INDEX));
    assign bank_sel   = wr_data[BANK_LSB +: BANK_SEL_W];
    assign bit_sel    = wr_data[BIT_LSB +: BIT_SEL_W];
    assign unused_low = ^wr_data[BIT_LSB-1:0];

    // One set mask per status register; only the selected one can be non-zero.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mask
        always_comb begin
            set_mask[b] = '0;
            if (hit && (bank_sel == BANK_SEL_W'(b)))
                set_mask[b][bit_sel] = 1'b1;
        end
    end
endmodule

// File: rtl/msg_status_word.sv
// Module: msg_status_word
// One sticky status register. Set bits OR in; a clear request empties the
// register, and a set arriving in the same cycle survives the clear.
module msg_status_word #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] set_bits,
    output logic [DATA_W-1:0] value
);
    // Hold, clear and merge new bits, with new bits taking precedence over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else
            value <= (clr ? '0 : value) | set_bits;
    end
endmodule

// File: rtl/msg_read_port.sv
// Module: msg_read_port
// Decodes read offsets: returns a status register (and requests its clear),
// the summary word, or zero for unmapped offsets. Purely combinational.
module msg_read_port #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [NUM_BANKS-1:0][DATA_W-1:0] status,
    input  logic [NUM_BANKS-1:0]             nonzero,
    output logic [NUM_BANKS-1:0]             clr,
    output logic [DATA_W-1:0]                rd_value
);
    import msg_irq_pkg::*;

    localparam int BANK_SEL_W = $clog2(NUM_BANKS);
    localparam int STAT_SPAN  = NUM_BANKS << STRIDE_SHIFT;

    logic                  is_status;
    logic                  is_summary;
    logic [BANK_SEL_W-1:0] idx;

    assign is_status  = (rd_addr[STRIDE_SHIFT-1:0] == '0) &&
                        (int'(rd_addr) < STAT_SPAN);
    assign is_summary = (rd_addr == ADDR_W'(OFF_SUMMARY));
    assign idx        = rd_addr[STRIDE_SHIFT +: BANK_SEL_W];

    // Per-register clear strobes for a read of that status offset.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_clr
        assign clr[b] = rd_en && is_status && (idx == BANK_SEL_W'(b));
    end

    // Read data selection; unmapped offsets give zero.
    always_comb begin
        rd_value = '0;
        if (is_status)
            rd_value = status[idx];
        else if (is_summary)
            rd_value = DATA_W'(nonzero);
    end
endmodule

// File: rtl/msg_irq_bank.sv
// Module: msg_irq_bank (top)
// Message interrupt status bank: index writes set sticky bits, clearing
// reads drain them, a summary word flags non-empty registers, and irq is
// the OR of all bits. Assumes DATA_W >= NUM_BANKS and ADDR_W >= 9.
module msg_irq_bank #(
    parameter int NUM_BANKS = 8,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NUM_BANKS-1:0][DATA_W-1:0] set_mask;
    logic [NUM_BANKS-1:0][DATA_W-1:0] status;
    logic [NUM_BANKS-1:0]             nonzero;
    logic [NUM_BANKS-1:0]             clr;
    logic [DATA_W-1:0]                rd_value;

    msg_index_decode #(
        .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .set_mask(set_mask)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        msg_status_word #(.DATA_W(DATA_W)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr[b]),
            .set_bits(set_mask[b]),
            .value   (status[b])
        );
        assign nonzero[b] = |status[b];
    end

    msg_read_port #(
        .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_read (
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .status  (status),
        .nonzero (nonzero),
        .clr     (clr),
        .rd_value(rd_value)
    );

    // Capture read data on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_value;
    end

    assign irq = |nonzero;
endmodule

// File: rtl/msg_irq_bank_checker.sv
// Module: msg_irq_bank_checker
// Port-level properties of the message interrupt bank, bound to the top.
module msg_irq_bank_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int NUM_BANKS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq
);
    import msg_irq_pkg::*;

    logic idx_wr, stat_rd, mapped_rd;
    assign idx_wr    = wr_en && (wr_addr == ADDR_W'(OFF_INDEX));
    assign stat_rd   = (rd_addr[STRIDE_SHIFT-1:0] == '0) &&
                       (int'(rd_addr) < (NUM_BANKS << STRIDE_SHIFT));
    assign mapped_rd = stat_rd || (rd_addr == ADDR_W'(OFF_SUMMARY));

    // R2 / R6: an index write always leaves irq high next cycle.
    p_index_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> irq);

    // R5: without an index write, irq cannot rise.
    p_no_rise_without_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !idx_wr) |=> !irq);

    // R6: irq only falls right after a read.
    p_irq_falls_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_en));

    // R8: unmapped reads give zero.
    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped_rd) |=> (rd_data == '0));

    // R3: back-to-back read of one status register with no writes returns zero.
    p_reread_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && stat_rd && !wr_en) ##1 (rd_en && $stable(rd_addr) && !wr_en)
        |=> (rd_data == '0));

    // R1: data bus stays quiet until a read happens.
    p_quiet_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en && $stable(rd_data)) |=> (!$past(rd_en) -> $stable(rd_data)));

    logic unused_wd;
    assign unused_wd = ^wr_data;
endmodule

bind msg_irq_bank msg_irq_bank_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
);

// File: tb/msg_irq_bank_test.sv
module msg_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    msg_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit is_stat(logic [11:0] a);
        return (a[3:0] == 4'h0) && (a < 12'h080);
    endfunction

    function automatic logic [31:0] summary();
        logic [31:0] s = '0;
        for (int k = 0; k < 8; k++) s[k] = (model[k] != 0);
        return s;
    endfunction

    function automatic bit model_irq();
        return summary() != 0;
    endfunction

    function automatic logic [31:0] idx_word(int bank, int bitn);
        return {bank[2:0], bitn[4:0], 24'(($urandom))};
    endfunction

    // One bus cycle from a negedge; checks read data and irq at the next negedge.
    task automatic step(bit we, logic [11:0] wa, logic [31:0] wd,
                        bit re, logic [11:0] ra, string rtag);
        logic [31:0] exp_rd;
        string tag;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        @(posedge clk);
        exp_rd = 32'h0;
        if (re && is_stat(ra)) begin
            exp_rd = model[ra[6:4]];
            model[ra[6:4]] = 32'h0;
        end else if (re && ra == 12'h120) begin
            exp_rd = summary();
        end
        if (we && wa == 12'h140)
            model[wd[31:29]][wd[28:24]] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (re) begin
            tag = rtag;
            if (tag == "") tag = is_stat(ra) ? "R3" : (ra == 12'h120 ? "R4" : "R8");
            check(tag, rd_data, exp_rd);
        end
        check("R6 irq", {31'b0, irq}, {31'b0, model_irq()});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 8; k++) model[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        step(0, 0, 0, 1, 12'h120, "R1");
        step(0, 0, 0, 1, 12'h070, "R1");
        // R2: set bank 3 bit 5
        step(1, 12'h140, idx_word(3, 5), 0, 0, "");
        step(0, 0, 0, 1, 12'h120, "R4");
        step(0, 0, 0, 1, 12'h030, "R2");
        step(0, 0, 0, 1, 12'h030, "R3");
        // R9: accumulation with extreme bits
        step(1, 12'h140, idx_word(7, 0), 0, 0, "");
        step(1, 12'h140, idx_word(7, 31), 0, 0, "");
        step(1, 12'h140, idx_word(7, 31), 0, 0, "");
        step(1, 12'h140, idx_word(0, 31), 0, 0, "");
        step(0, 0, 0, 1, 12'h070, "R9");
        step(0, 0, 0, 1, 12'h000, "R2");
        // R5: other writes ignored
        step(1, 12'h030, 32'hFFFF_FFFF, 0, 0, "");
        step(1, 12'h120, 32'hFFFF_FFFF, 0, 0, "");
        step(1, 12'h144, 32'hFFFF_FFFF, 0, 0, "");
        step(0, 0, 0, 1, 12'h120, "R5");
        step(0, 0, 0, 1, 12'h030, "R5");
        // R7: collision on register 2
        step(1, 12'h140, idx_word(2, 9), 0, 0, "");
        step(1, 12'h140, idx_word(2, 17), 1, 12'h020, "R7");
        step(0, 0, 0, 1, 12'h020, "R7");
        // R8: unmapped read with state present
        step(1, 12'h140, idx_word(4, 1), 1, 12'h024, "R8");
        step(0, 0, 0, 1, 12'h100, "R8");
        step(0, 0, 0, 1, 12'h040, "R3");
        // random phase
        for (int i = 0; i < 3000; i++) begin
            int sel = $urandom_range(0, 9);
            bit we = 0, re = 0;
            logic [11:0] wa = '0, ra = '0;
            logic [31:0] wd = $urandom;
            if (sel < 5) begin we = 1; wa = 12'h140; end
            else if (sel == 5) begin we = 1; wa = 12'($urandom); end
            if ($urandom_range(0, 2) == 0 || sel >= 7) begin
                re = 1;
                case ($urandom_range(0, 3))
                    0: ra = 12'h120;
                    1: ra = 12'($urandom);
                    default: ra = {5'b0, 3'($urandom), 4'h0};
                endcase
            end
            step(we, wa, wd, re, ra, "");
        end
        // drain all and confirm irq drops (R6)
        for (int k = 0; k < 8; k++) step(0, 0, 0, 1, {5'b0, 3'(k), 4'h0}, "R3");
        check("R6 drained", {31'b0, irq}, 32'h0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule